// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor that issues single-byte reads and writes and a memory that moves whole 4-byte lines. Each processor address is cut into three fields: a byte offset at the bottom, a set index above it, and a tag in the remaining upper bits. The set index picks one set. Each set holds two lines, and the stored tags of both lines are compared with the request tag at the same time. When neither line matches, one line of the set is chosen as the victim. If the victim holds modified data it is first copied back to memory. The missing line is then fetched whole, and only after that is the request answered.

Writes only change the cache and mark the line modified. Memory sees modified data only when that line is evicted. A single bit per set records which of the two lines was used last, and on a miss the other line is replaced. Empty lines are always used before any valid line is displaced. The processor keeps its request asserted until a one-cycle ready pulse returns, and read data is valid during that pulse. The set-index width is a parameter. The full-size split is 9 tag, 13 set and 2 offset bits of a 24-bit address. Smaller set counts move the freed bits into the tag.

Top module: `wsa_cache`

## Requirements
- R1: For an address, the offset is bits [1:0], the set index is the next SET_W bits, and the tag is all bits above that. A line is 32 bits, and byte k of a line is held in bits [8k+7:8k].
- R2: While reset is held, cpu_ready and mem_req are low. After reset every line is invalid, so the first access to any address misses.
- R3: A request whose tag matches a valid line in either way of its set is a hit. It raises cpu_ready two clock edges after being sampled and causes no memory transaction.
- R4: A read miss issues one memory read of block address addr[23:2]. It returns the requested byte of the fetched line.
- R5: When the indexed set has an invalid way, the miss fills it (way 0 before way 1) and no line is evicted or written back.
- R6: When both ways are valid, the way not referenced by the most recent access to that set is replaced.
- R7: A write that hits updates only the cached byte and marks the line modified. No memory write occurs.
- R8: Evicting a modified line first writes the whole line to its own block address, then reads the new block. A clean victim is overwritten with no memory write. The miss latency is 6 edges with a write-back and 4 without.
- R9: A write miss fetches the block, stores the write byte into the fetched line, and marks the line modified. The other bytes keep the fetched values.
- R10: cpu_ready is a single-cycle pulse. A memory request keeps mem_we and mem_addr stable until mem_ack.
- R11: Two blocks with different tags and the same set index can be resident together, and both then hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request pending, held until cpu_ready |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid while cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_addr | output | ADDR_W-2 | Block address |
| mem_wdata | output | 32 | Line being written back |
| mem_rdata | input | 32 | Fetched line, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion from memory |

## Verification
The bench first walks one set through a fixed sequence. That sequence fills an empty way, hits in both ways, evicts a modified line, and fetches that line back. If the design wrote back a clean victim, or dropped a modified one, the wrong number of memory writes would appear, or the byte written earlier would come back with its old value. A design that got the recency bit backwards would evict the line just touched, and the later hit on the kept line would be seen as a miss with fetch latency. The bench then runs a long random run over a few conflicting tags in a small set count. It compares every byte read, every memory read and write count, every write-back address, and every latency against a behavioural model. This run exposes a wrong field split, lost merges on write misses, and byte lanes that are swapped.

// File: rtl/wsa_pkg.sv
package wsa_pkg;
    localparam int WAYS   = 2;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COMPARE,
        ST_WRITEBACK,
        ST_REFILL,
        ST_RESPOND
    } wsa_state_e;
endpackage

// File: rtl/wsa_way_store.sv
module wsa_way_store #(
    parameter int SET_W  = 5,
    parameter int TAG_W  = 17,
    parameter int LINE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic              wr_dirty,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_data
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] data_q [SETS];

    // status bits are cleared by reset; tags and data need no reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[idx]  <= wr_tag;
            data_q[idx] <= wr_data;
        end
    end

    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_tag   = tag_q[idx];
    assign rd_data  = data_q[idx];
endmodule

// File: rtl/wsa_lookup.sv
module wsa_lookup #(
    parameter int TAG_W = 17
) (
    input  logic [1:0]            valid,
    input  logic [1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]      req_tag,
    input  logic                  mru,
    output logic                  any_hit,
    output logic                  hit_way,
    output logic                  victim_way
);
    logic [1:0] hit;

    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign hit[w] = valid[w] && (tags[w] == req_tag);
    end

    assign any_hit = |hit;
    assign hit_way = hit[1];

    // empty ways first, otherwise the way not used last
    always_comb begin
        if (!valid[0])      victim_way = 1'b0;
        else if (!valid[1]) victim_way = 1'b1;
        else                victim_way = ~mru;
    end
endmodule

// File: rtl/wsa_cache.sv
module wsa_cache
    import wsa_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int SET_W  = 5,
    parameter int OFF_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_valid,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [7:0]              cpu_wdata,
    output logic [7:0]              cpu_rdata,
    output logic                    cpu_ready,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-OFF_W-1:0] mem_addr,
    output logic [(8<<OFF_W)-1:0]   mem_wdata,
    input  logic [(8<<OFF_W)-1:0]   mem_rdata,
    input  logic                    mem_ack
);
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
    localparam int LINE_W = BYTE_W << OFF_W;
    localparam int SETS   = 1 << SET_W;

    typedef struct packed {
        wsa_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [7:0]        wdata;
        logic              way;
        logic [7:0]        rdata;
        logic [SETS-1:0]   mru;
    } regs_t;

    regs_t q, d;

    logic [OFF_W-1:0] q_off;
    logic [SET_W-1:0] q_set;
    logic [TAG_W-1:0] q_tag;
    assign q_off = q.addr[OFF_W-1:0];
    assign q_set = q.addr[OFF_W +: SET_W];
    assign q_tag = q.addr[ADDR_W-1 -: TAG_W];

    logic [1:0]             way_valid, way_dirty;
    logic [1:0][TAG_W-1:0]  way_tag;
    logic [1:0][LINE_W-1:0] way_data;
    logic [1:0]             wr_en;
    logic                   wr_dirty;
    logic [LINE_W-1:0]      wr_data;
    logic                   any_hit, hit_way, victim_way;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        wsa_way_store #(.SET_W(SET_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .idx     (q_set),
            .rd_valid(way_valid[w]),
            .rd_dirty(way_dirty[w]),
            .rd_tag  (way_tag[w]),
            .rd_data (way_data[w]),
            .wr_en   (wr_en[w]),
            .wr_dirty(wr_dirty),
            .wr_tag  (q_tag),
            .wr_data (wr_data)
        );
    end

    wsa_lookup #(.TAG_W(TAG_W)) u_lookup (
        .valid     (way_valid),
        .tags      (way_tag),
        .req_tag   (q_tag),
        .mru       (q.mru[q_set]),
        .any_hit   (any_hit),
        .hit_way   (hit_way),
        .victim_way(victim_way)
    );

    logic [LINE_W-1:0] base_line, merged_line;

    always_comb begin
        d         = q;
        wr_en     = '0;
        wr_dirty  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {q_tag, q_set};
        mem_wdata = way_data[q.way];
        cpu_ready = 1'b0;

        base_line   = (q.st == ST_REFILL) ? mem_rdata : way_data[hit_way];
        merged_line = base_line;
        merged_line[int'(q_off)*8 +: 8] = q.wdata;
        wr_data = q.we ? merged_line : base_line;

        unique case (q.st)
            ST_IDLE: begin
                if (cpu_valid) begin
                    d.addr  = cpu_addr;
                    d.we    = cpu_we;
                    d.wdata = cpu_wdata;
                    d.st    = ST_COMPARE;
                end
            end
            ST_COMPARE: begin
                if (any_hit) begin
                    d.way        = hit_way;
                    d.mru[q_set] = hit_way;
                    d.rdata      = base_line[int'(q_off)*8 +: 8];
                    if (q.we) begin
                        wr_en[hit_way] = 1'b1;
                        wr_dirty       = 1'b1;
                    end
                    d.st = ST_RESPOND;
                end else begin
                    d.way = victim_way;
                    d.st  = (way_valid[victim_way] && way_dirty[victim_way])
                            ? ST_WRITEBACK : ST_REFILL;
                end
            end
            ST_WRITEBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {way_tag[q.way], q_set};
                if (mem_ack) d.st = ST_REFILL;
            end
            ST_REFILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    wr_en[q.way] = 1'b1;
                    wr_dirty     = q.we;
                    d.mru[q_set] = q.way;
                    d.rdata      = mem_rdata[int'(q_off)*8 +: 8];
                    d.st         = ST_RESPOND;
                end
            end
            ST_RESPOND: begin
                cpu_ready = 1'b1;
                d.st      = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign cpu_rdata = q.rdata;
endmodule

// File: rtl/wsa_cache_chk.sv
module wsa_cache_chk #(
    parameter int BLK_W = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_valid,
    input logic             cpu_ready,
    input logic             mem_req,
    input logic             mem_we,
    input logic [BLK_W-1:0] mem_addr,
    input logic             mem_ack
);
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r2_quiet_in_reset: assert (!cpu_ready && !mem_req)
                else $error("R2: output active during reset");
        end
    end

    a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r8_fetch_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    a_r4_mem_only_on_pending: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (cpu_valid && !cpu_ready));

    a_r7_we_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);
endmodule

bind wsa_cache wsa_cache_chk #(.BLK_W(ADDR_W - OFF_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_valid(cpu_valid),
    .cpu_ready(cpu_ready),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack)
);

// File: tb/wsa_cache_tb.sv
module wsa_cache_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 24;
    localparam int SET_W  = 3;
    localparam int OFF_W  = 2;
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
    localparam int SETS   = 1 << SET_W;
    localparam int BLK_W  = ADDR_W - OFF_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_valid = 1'b0;
    logic              cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [7:0]        cpu_wdata = '0;
    logic [7:0]        cpu_rdata;
    logic              cpu_ready;
    logic              mem_req, mem_we;
    logic [BLK_W-1:0]  mem_addr;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata = '0;
    logic              mem_ack = 1'b0;

    int checks = 0;
    int failures = 0;
    int nrd = 0;
    int nwr = 0;
    int last_wr_blk = -1;

    always #(CLK_PERIOD/2) clk = ~clk;

    wsa_cache #(.ADDR_W(ADDR_W), .SET_W(SET_W), .OFF_W(OFF_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // backing memory: untouched blocks hold a value computed from the block number
    logic [31:0] mem [int];
    logic [7:0]  shadow [int];

    function automatic logic [31:0] init_line(int blk);
        return (blk * 32'h9E37_79B1) ^ 32'h0BAD_F00D;
    endfunction

    function automatic logic [31:0] mem_line(int blk);
        if (mem.exists(blk)) return mem[blk];
        return init_line(blk);
    endfunction

    function automatic logic [7:0] exp_byte(int a);
        logic [31:0] l;
        if (shadow.exists(a)) return shadow[a];
        l = init_line(a >> 2);
        return l[(a & 3)*8 +: 8];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                if (mem_we) begin
                    mem[int'(mem_addr)] = mem_wdata;
                    nwr++;
                    last_wr_blk = int'(mem_addr);
                end else begin
                    nrd++;
                end
                mem_rdata <= mem_line(int'(mem_addr));
            end
        end
    end

    // behavioural model of the cache directory
    logic             ref_v   [2][SETS];
    logic             ref_d   [2][SETS];
    logic [TAG_W-1:0] ref_t   [2][SETS];
    logic             ref_mru [SETS];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk(int tag, int set, int off);
        return {tag[TAG_W-1:0], set[SET_W-1:0], off[OFF_W-1:0]};
    endfunction

    task automatic do_req(input logic [ADDR_W-1:0] a, input bit we, input logic [7:0] wd,
                          input string req);
        int set, way, cyc, rd0, wr0, exp_lat, wb_blk;
        logic [TAG_W-1:0] tag;
        bit hit, wb;
        set = int'(a[OFF_W +: SET_W]);
        tag = a[ADDR_W-1 -: TAG_W];
        hit = 0; wb = 0; way = 0; wb_blk = -1;
        for (int w = 0; w < 2; w++)
            if (ref_v[w][set] && ref_t[w][set] == tag) begin hit = 1; way = w; end
        if (hit) begin
            if (we) ref_d[way][set] = 1'b1;
        end else begin
            if (!ref_v[0][set])      way = 0;
            else if (!ref_v[1][set]) way = 1;
            else                     way = ref_mru[set] ? 0 : 1;
            wb = ref_v[way][set] && ref_d[way][set];
            wb_blk = int'({ref_t[way][set], set[SET_W-1:0]});
            ref_v[way][set] = 1'b1;
            ref_t[way][set] = tag;
            ref_d[way][set] = we;
        end
        ref_mru[set] = way[0];
        exp_lat = hit ? 2 : (wb ? 6 : 4);

        rd0 = nrd; wr0 = nwr;
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        cyc = 0;
        do begin
            @(posedge clk); cyc++;
            @(negedge clk);
        end while (!cpu_ready && cyc < 100);
        check(cyc == exp_lat, {req, " latency"}, cyc, exp_lat);
        check((nrd - rd0) == (hit ? 0 : 1), {req, " memory reads"}, nrd - rd0, hit ? 0 : 1);
        check((nwr - wr0) == (wb ? 1 : 0), {req, " memory writes"}, nwr - wr0, wb ? 1 : 0);
        if (wb) check(last_wr_blk == wb_blk, {req, " write-back block"}, last_wr_blk, wb_blk);
        if (!we) check(cpu_rdata == exp_byte(int'(a)), {req, " read byte"},
                       cpu_rdata, exp_byte(int'(a)));
        else shadow[int'(a)] = wd;
        cpu_valid = 1'b0;
        @(negedge clk);
        check(!cpu_ready, "R10 ready pulse width", cpu_ready, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int s = 0; s < SETS; s++) begin
            ref_mru[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin
                ref_v[w][s] = 1'b0; ref_d[w][s] = 1'b0; ref_t[w][s] = '0;
            end
        end
        repeat (3) @(negedge clk);
        check(!cpu_ready && !mem_req, "R2 outputs in reset", {cpu_ready, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed walk through set 5
        do_req(mk(1, 5, 1), 1'b0, 8'h00, "R2 R4 first read misses");
        do_req(mk(1, 5, 3), 1'b0, 8'h00, "R3 R1 hit other byte");
        do_req(mk(1, 5, 2), 1'b1, 8'h5A, "R7 write hit");
        do_req(mk(1, 5, 2), 1'b0, 8'h00, "R7 R1 read merged byte");
        do_req(mk(2, 5, 0), 1'b0, 8'h00, "R5 fill empty way");
        do_req(mk(1, 5, 0), 1'b0, 8'h00, "R11 first tag hits");
        do_req(mk(2, 5, 3), 1'b0, 8'h00, "R11 second tag hits");
        do_req(mk(3, 5, 1), 1'b0, 8'h00, "R8 R6 dirty eviction");
        do_req(mk(2, 5, 1), 1'b0, 8'h00, "R6 recent line kept");
        do_req(mk(1, 5, 2), 1'b0, 8'h00, "R8 clean victim, written byte returns");
        do_req(mk(4, 5, 0), 1'b1, 8'hC3, "R9 write miss");
        do_req(mk(4, 5, 0), 1'b0, 8'h00, "R9 merged byte");
        do_req(mk(4, 5, 1), 1'b0, 8'h00, "R9 fetched bytes kept");
        do_req(mk(4, 5, 3), 1'b0, 8'h00, "R9 R1 top lane");
        do_req(mk(9'h1FF, 7, 0), 1'b0, 8'h00, "R1 R5 upper tag");
        do_req(mk(9'h001, 7, 0), 1'b0, 8'h00, "R11 R1 same set other tag");

        // random sweep over conflicting tags
        for (int i = 0; i < 3000; i++) begin
            int t, s, o;
            bit w;
            t = int'($urandom_range(0, 3)) * 37 + 1;
            s = int'($urandom_range(0, SETS - 1));
            o = int'($urandom_range(0, 3));
            w = ($urandom_range(0, 2) == 0);
            do_req(mk(t, s, o), w, 8'($urandom), "R4 R6 R8 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule